// File: doc/BRIEF.md
# Boot Cassette Restart and Rewind Sequencer

This block controls the tape transport that loads the boot program. When the operator presses the restart key, two status flags (interrupt and sync) are raised. The chosen deck is wound back to its leader, and then the deck is run forward so the loader can read the tape. The status flags fall at the moment forward playback begins. A stop key halts the transport at any time, and a later restart runs the whole sequence again.

The restart key arrives asynchronously. It passes through a flip-flop synchronizer and an edge detector, so one press, however long it is held, starts exactly one sequence. Rewind ends when the end-of-tape sensor of the active deck reports the leader. The sensor of the other deck is ignored. Each deck also gives a strobe pulse while its tape moves. A retriggerable one-shot, fed by both decks, turns these pulses into a steady tape-motion indication.

Sensor and strobe inputs are clean synchronous logic levels and pulses. Motor drive and data recovery are not part of this block.

Top module: `boot_tape_seq`

## Requirements
- R1: After reset, intr_flag and sync_flag are 1, and rewind_cmd, forward_cmd and motion are 0.
- R2: A rising edge on restart_key passes two synchronizer stages and an edge detector. The flags are preset 3 clocks after the edge is sampled, and rewind_cmd rises one clock after that. Holding the key down does not start a second sequence.
- R3: Every accepted restart sets intr_flag and sync_flag to 1, even if they were cleared earlier.
- R4: End-of-tape is taken from eot_a when deck_sel is 0 and from eot_b when deck_sel is 1. With the default parameter, a 1 on an eot input means end-of-tape. The sensor of the deck that is not selected has no effect.
- R5: While rewinding, a selected end-of-tape ends the rewind at the next clock. One clock follows with both commands at 0, and then forward_cmd rises.
- R6: If the selected end-of-tape is already active when a restart is accepted, no rewind happens. The transport goes to forward motion after the single arming clock, without stalling.
- R7: intr_flag and sync_flag drop to 0 in the same clock in which forward_cmd rises.
- R8: A 1 on stop_key forces rewind_cmd and forward_cmd to 0 at the next clock and leaves the flags unchanged. A later restart runs the full sequence again.
- R9: rewind_cmd and forward_cmd are never 1 together. Every change of direction has at least one clock with both at 0, including a restart that arrives during forward motion.
- R10: motion rises one clock after a strobe from either deck. It stays 1 for exactly MOTION_HOLD clocks after the most recent strobe, and each new strobe restarts that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart_key | input | 1 | Restart request, asynchronous level |
| stop_key | input | 1 | Stop request, synchronous level |
| deck_sel | input | 1 | Active deck: 0 = deck A, 1 = deck B |
| eot_a | input | 1 | End-of-tape sensor, deck A |
| eot_b | input | 1 | End-of-tape sensor, deck B |
| strobe_a | input | 1 | Motion strobe pulse, deck A |
| strobe_b | input | 1 | Motion strobe pulse, deck B |
| intr_flag | output | 1 | Interrupt status flag |
| sync_flag | output | 1 | Sync status flag |
| rewind_cmd | output | 1 | Rewind motion command |
| forward_cmd | output | 1 | Forward playback command |
| motion | output | 1 | Tape-motion indication |

## Verification
The hardest situations to reach are the direction changes that happen while the transport is already moving. One is a restart that arrives during forward playback and must pass through an idle clock before rewinding. The other is a stop that interrupts a rewind, followed by a fresh restart. The bench reaches them by chaining complete sequences without a reset in between. It first plays one deck forward, then changes the deck selection and the sensor levels, so each new restart starts from a state that an earlier sequence left behind. The end-of-tape sensor of the deck that is not selected is held active during a rewind, to show that it has no effect.

// File: rtl/boot_tape_pkg.sv
package boot_tape_pkg;
   typedef enum logic [2:0] {
      TS_IDLE    = 3'd0,
      TS_ARM     = 3'd1,
      TS_REWIND  = 3'd2,
      TS_TURN    = 3'd3,
      TS_FORWARD = 3'd4
   } tape_state_t;
endpackage

// File: rtl/restart_edge_sync.sv
module restart_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic req_pulse
);
   // sh[0..STAGES-1] form the synchronizer, sh[STAGES] holds the previous sample
   logic [STAGES:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("restart_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], req_async};
   end

   assign req_pulse = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/motion_oneshot.sv
module motion_oneshot #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] RELOAD = CW'(HOLD);

   logic [CW-1:0] remain;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("motion_oneshot: HOLD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)            remain <= '0;
      else if (trig)         remain <= RELOAD;
      else if (remain != '0) remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/transport_ctrl.sv
module transport_ctrl
   import boot_tape_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go_pulse,
   input  logic halt,
   input  logic at_leader,
   output logic flags_q,
   output logic rew_o,
   output logic fwd_o
);
   tape_state_t st, nxt;

   always_comb begin
      nxt = st;
      if (halt)          nxt = TS_IDLE;
      else if (go_pulse) nxt = TS_ARM;
      else begin
         case (st)
            TS_ARM:    nxt = at_leader ? TS_FORWARD : TS_REWIND;
            TS_REWIND: if (at_leader) nxt = TS_TURN;
            TS_TURN:   nxt = TS_FORWARD;
            default:   nxt = st;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TS_IDLE;
         flags_q <= 1'b1;
      end else begin
         st <= nxt;
         if (!halt && go_pulse)
            flags_q <= 1'b1;
         else if (nxt == TS_FORWARD && st != TS_FORWARD)
            flags_q <= 1'b0;
      end
   end

   assign rew_o = (st == TS_REWIND);
   assign fwd_o = (st == TS_FORWARD);
endmodule

// File: rtl/boot_tape_seq.sv
module boot_tape_seq #(
   parameter int SYNC_STAGES  = 2,
   parameter int MOTION_HOLD  = 16,
   parameter bit EOT_ACT_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_key,
   input  logic stop_key,
   input  logic deck_sel,
   input  logic eot_a,
   input  logic eot_b,
   input  logic strobe_a,
   input  logic strobe_b,
   output logic intr_flag,
   output logic sync_flag,
   output logic rewind_cmd,
   output logic forward_cmd,
   output logic motion
);
   logic go_pulse;
   logic eot_raw;
   logic eot_hit;
   logic flags;

   restart_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .req_async(restart_key), .req_pulse(go_pulse)
   );

   assign eot_raw = deck_sel ? eot_b : eot_a;

   generate
      if (EOT_ACT_HIGH) begin : g_eot_hi
         assign eot_hit = eot_raw;
      end else begin : g_eot_lo
         assign eot_hit = ~eot_raw;
      end
   endgenerate

   transport_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .go_pulse(go_pulse), .halt(stop_key),
      .at_leader(eot_hit), .flags_q(flags), .rew_o(rewind_cmd), .fwd_o(forward_cmd)
   );

   motion_oneshot #(.HOLD(MOTION_HOLD)) u_motion (
      .clk(clk), .rst_n(rst_n), .trig(strobe_a | strobe_b), .active(motion)
   );

   assign intr_flag = flags;
   assign sync_flag = flags;
endmodule

// File: rtl/boot_tape_seq_chk.sv
module boot_tape_seq_chk #(
   parameter bit EOT_ACT_HIGH = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic stop_key,
   input logic deck_sel,
   input logic eot_a,
   input logic eot_b,
   input logic strobe_a,
   input logic strobe_b,
   input logic intr_flag,
   input logic sync_flag,
   input logic rewind_cmd,
   input logic forward_cmd,
   input logic motion
);
   logic leader_seen;
   assign leader_seen = ((deck_sel ? eot_b : eot_a) == EOT_ACT_HIGH);

   assert_dir_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rewind_cmd && forward_cmd));

   assert_gap_after_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_cmd |=> !forward_cmd);

   assert_gap_after_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
      forward_cmd |=> !rewind_cmd);

   assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_key |=> (!rewind_cmd && !forward_cmd));

   assert_eot_ends_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind_cmd && leader_seen) |=> !rewind_cmd);

   assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(forward_cmd) |-> (!intr_flag && !sync_flag));

   assert_strobe_motion_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_a || strobe_b) |=> motion);
endmodule

bind boot_tape_seq boot_tape_seq_chk #(.EOT_ACT_HIGH(EOT_ACT_HIGH)) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_key(stop_key), .deck_sel(deck_sel),
   .eot_a(eot_a), .eot_b(eot_b), .strobe_a(strobe_a), .strobe_b(strobe_b),
   .intr_flag(intr_flag), .sync_flag(sync_flag), .rewind_cmd(rewind_cmd),
   .forward_cmd(forward_cmd), .motion(motion)
);

// File: tb/tb_boot_tape_seq.sv
module tb_boot_tape_seq;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 16;
   localparam int WATCHDOG = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart_key = 1'b0, stop_key = 1'b0, deck_sel = 1'b0;
   logic eot_a = 1'b0, eot_b = 1'b0, strobe_a = 1'b0, strobe_b = 1'b0;
   logic intr_flag, sync_flag, rewind_cmd, forward_cmd, motion;

   boot_tape_seq #(.MOTION_HOLD(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .restart_key(restart_key), .stop_key(stop_key),
      .deck_sel(deck_sel), .eot_a(eot_a), .eot_b(eot_b), .strobe_a(strobe_a),
      .strobe_b(strobe_b), .intr_flag(intr_flag), .sync_flag(sync_flag),
      .rewind_cmd(rewind_cmd), .forward_cmd(forward_cmd), .motion(motion)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // expected vector order: {intr, sync, rewind, forward, motion}
   typedef struct {
      int         cyc;
      string      req;
      logic [4:0] exp;
      logic [4:0] msk;
   } item_t;

   item_t sb[$];
   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int delta, input string req,
                            input logic [4:0] exp, input logic [4:0] msk);
      item_t it;
      it.cyc = cyc + delta; it.req = req; it.exp = exp; it.msk = msk;
      sb.push_back(it);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic press(input int len);
      restart_key = 1'b1; step(len); restart_key = 1'b0;
   endtask

   // monitor: compares queued expectations in their target cycle
   always @(negedge clk) begin
      logic [4:0] act;
      act = {intr_flag, sync_flag, rewind_cmd, forward_cmd, motion};
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (it.cyc != cyc || ((act ^ it.exp) & it.msk) != 5'b0) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                     it.req, cyc, act, it.exp, it.msk);
         end
      end
   end

   localparam logic [4:0] CMDS = 5'b11110;
   localparam logic [4:0] MOT  = 5'b00001;

   initial begin
      step(3);
      rst_n = 1'b1;
      expect_at(1, "R1", 5'b11000, 5'b11111);
      step(3);

      // deck A rewind, deck B sensor active but ignored
      deck_sel = 1'b0; eot_b = 1'b1;
      restart_key = 1'b1;
      expect_at(3, "R2", 5'b11000, CMDS);
      expect_at(4, "R2", 5'b11100, CMDS);
      expect_at(10, "R2_held_R4", 5'b11100, CMDS);
      step(10);
      eot_a = 1'b1;
      expect_at(1, "R5_gap_R9", 5'b11000, CMDS);
      expect_at(2, "R7_R5", 5'b00010, CMDS);
      step(4);
      restart_key = 1'b0;
      step(4);

      // stop during forward
      stop_key = 1'b1;
      expect_at(1, "R8", 5'b00000, CMDS);
      step(1); stop_key = 1'b0;
      step(4);

      // end-of-tape already active at restart
      press(1);
      expect_at(2, "R3", 5'b11000, CMDS);
      expect_at(3, "R6", 5'b00010, CMDS);
      step(8);

      // deck B, deck A sensor active but ignored
      stop_key = 1'b1; step(1); stop_key = 1'b0;
      deck_sel = 1'b1; eot_a = 1'b1; eot_b = 1'b0;
      step(2);
      press(1);
      expect_at(2, "R2_deckB", 5'b11000, CMDS);
      expect_at(3, "R4", 5'b11100, CMDS);
      expect_at(7, "R4_other_ignored", 5'b11100, CMDS);
      step(7);
      eot_b = 1'b1;
      expect_at(1, "R5_deckB", 5'b11000, CMDS);
      expect_at(2, "R7_deckB", 5'b00010, CMDS);
      step(5);

      // restart during forward: idle clock then rewind
      eot_b = 1'b0;
      press(1);
      expect_at(2, "R9_fwd_to_rew", 5'b11000, CMDS);
      expect_at(3, "R9_rewind", 5'b11100, CMDS);
      step(5);

      // stop during rewind keeps flags, then restart again
      stop_key = 1'b1;
      expect_at(1, "R8_stop_rewind", 5'b11000, CMDS);
      step(1); stop_key = 1'b0;
      step(2);
      press(1);
      expect_at(3, "R8_rerun", 5'b11100, CMDS);
      step(6);
      stop_key = 1'b1; step(1); stop_key = 1'b0;
      step(2);

      // motion one-shot, retriggered from the other deck
      strobe_a = 1'b1;
      expect_at(1, "R10_rise", 5'b00001, MOT);
      expect_at(16, "R10_hold", 5'b00001, MOT);
      expect_at(HOLD + 10, "R10_retrig", 5'b00001, MOT);
      expect_at(HOLD + 11, "R10_drop", 5'b00000, MOT);
      step(1); strobe_a = 1'b0;
      step(9);
      strobe_b = 1'b1; step(1); strobe_b = 1'b0;
      step(HOLD + 6);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule